// File: doc/BRIEF.md
# Set/Clear GPIO Port

This block is a general-purpose I/O port of up to 32 lines. Software reaches it through a simple 32-bit register bus with address, write strobe, write data, read strobe and read data. Output levels, line directions and per-line input debounce are each changed through a pair of addresses. Writing a 1 to the set address of a pair turns bits on, and writing a 1 to the clear address turns them off. Bits written as 0 are left alone, so one line never disturbs another and no read-modify-write is needed.

The pad side has three vectors. The block drives the output vector and the output-enable vector and takes the input vector. Pad inputs pass through a two-flop synchronizer. Each line can then go through an optional stability filter before the level is captured in the external-level register, which software reads. The direction bits can also be read back through a separate status address. The number of lines and the filter length are parameters.

Top module: `gpio_sc_port`

## Requirements
- R1: After reset, `pad_out`, `pad_oe` and `bus_rdata` are all zero and debounce is off for every line.
- R2: A write to 0x000 sets every output-data bit where the write data holds a 1 and leaves the others unchanged; `pad_out` shows the new value from the clock edge that takes the write.
- R3: A write to 0x004 clears every output-data bit where the write data holds a 1 and leaves the others unchanged.
- R4: A write to 0x010 sets direction bits and a write to 0x014 clears them; a direction bit of 1 makes the line an output, and `pad_oe` equals the direction bits.
- R5: A read issued with `bus_ren` at one clock edge returns its data on `bus_rdata` after that edge. A read of 0x018 returns the direction bits. `bus_rdata` is zero after any edge where `bus_ren` was low.
- R6: A read of 0x080 returns the captured pad levels. With debounce off, a change on `pad_in` reaches this register at the third clock edge after it (two synchronizer stages and the capture stage).
- R7: A write to 0x060 enables debounce for lines whose write-data bit is 1, and a write to 0x064 disables it. With debounce on, a line's captured level changes only after the synchronized input has differed from the filtered level for `DB_CYCLES` consecutive cycles. A pulse shorter than that has no effect on it.
- R8: The set-only and clear-only addresses (0x000, 0x004, 0x010, 0x014, 0x060, 0x064) read as zero. Any address that is not one of the defined offsets, including a misaligned one, reads as zero. A write to such an address changes no output.
- R9: Bits at positions `NUM_LINES` and above read as zero and are ignored on writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_ren | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| pad_in | input | NUM_LINES | Pad input levels, asynchronous |
| pad_out | output | NUM_LINES | Pad output levels |
| pad_oe | output | NUM_LINES | Pad output enables, 1 = drive |

## Verification
The assertions assume that `bus_wen` and `bus_ren` are never high in the same cycle. They also assume that the write data for a strobe is stable at the clock edge that samples it, and that `rst_n` is low from time zero. The bench drives all bus and pad inputs on the falling clock edge and issues a single strobe per access, so each access occupies one rising edge. The pad input also changes only on falling edges, so the synchronizer is never exercised with metastable timing. Any violation of these assumptions would break the cycle count of the filter model.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;
    // Register byte offsets; each register is one 32-bit word.
    localparam int OFS_DOUT_SET = 'h000;
    localparam int OFS_DOUT_CLR = 'h004;
    localparam int OFS_DIR_SET  = 'h010;
    localparam int OFS_DIR_CLR  = 'h014;
    localparam int OFS_DIR_STAT = 'h018;
    localparam int OFS_DBN_SET  = 'h060;
    localparam int OFS_DBN_CLR  = 'h064;
    localparam int OFS_PIN_LVL  = 'h080;
    localparam int MAX_LINES    = 32;
endpackage

// File: rtl/gpio_sc_sync.sv
module gpio_sc_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] stage1;
        logic [W-1:0] stage2;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.stage1 = async_i;
        s_d.stage2 = s_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_o = s_q.stage2;
endmodule

// File: rtl/gpio_sc_debounce.sv
module gpio_sc_debounce #(
    parameter int W         = 32,
    parameter int DB_CYCLES = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] en_i,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] filt_o
);
    localparam int CNT_W = (DB_CYCLES > 1) ? $clog2(DB_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DB_CYCLES - 1);

    for (genvar i = 0; i < W; i++) begin : g_line
        typedef struct packed {
            logic             lvl;
            logic [CNT_W-1:0] cnt;
        } flt_t;

        flt_t f_d, f_q;

        always_comb begin
            f_d = f_q;
            if (!en_i[i]) begin
                f_d.lvl = raw_i[i];
                f_d.cnt = '0;
            end else if (raw_i[i] == f_q.lvl) begin
                f_d.cnt = '0;
            end else if (f_q.cnt == CNT_LAST) begin
                f_d.lvl = raw_i[i];
                f_d.cnt = '0;
            end else begin
                f_d.cnt = f_q.cnt + 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) f_q <= '0;
            else        f_q <= f_d;
        end

        assign filt_o[i] = en_i[i] ? f_q.lvl : raw_i[i];

        // R7
        filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (DB_CYCLES > 1) && en_i[i] && (f_q.cnt == '0) |=> $stable(f_q.lvl));
    end
endmodule

// File: rtl/gpio_sc_port.sv
module gpio_sc_port
    import gpio_sc_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int DB_CYCLES = 4,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wen,
    input  logic [31:0]          bus_wdata,
    input  logic                 bus_ren,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] pad_in,
    output logic [NUM_LINES-1:0] pad_out,
    output logic [NUM_LINES-1:0] pad_oe
);
    localparam int N = (NUM_LINES > MAX_LINES) ? MAX_LINES : NUM_LINES;

    typedef struct packed {
        logic [N-1:0] dout;
        logic [N-1:0] dir;
        logic [N-1:0] dbn;
        logic [N-1:0] lvl;
        logic [31:0]  rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic [N-1:0] sync_lvl;
    logic [N-1:0] filt_lvl;
    logic [N-1:0] wbits;

    logic hit_dout_set, hit_dout_clr, hit_dir_set, hit_dir_clr;
    logic hit_dir_stat, hit_dbn_set, hit_dbn_clr, hit_pin_lvl;

    assign hit_dout_set = (bus_addr == ADDR_W'(OFS_DOUT_SET));
    assign hit_dout_clr = (bus_addr == ADDR_W'(OFS_DOUT_CLR));
    assign hit_dir_set  = (bus_addr == ADDR_W'(OFS_DIR_SET));
    assign hit_dir_clr  = (bus_addr == ADDR_W'(OFS_DIR_CLR));
    assign hit_dir_stat = (bus_addr == ADDR_W'(OFS_DIR_STAT));
    assign hit_dbn_set  = (bus_addr == ADDR_W'(OFS_DBN_SET));
    assign hit_dbn_clr  = (bus_addr == ADDR_W'(OFS_DBN_CLR));
    assign hit_pin_lvl  = (bus_addr == ADDR_W'(OFS_PIN_LVL));

    assign wbits = bus_wdata[N-1:0];

    gpio_sc_sync #(.W(N)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pad_in[N-1:0]),
        .sync_o (sync_lvl)
    );

    gpio_sc_debounce #(.W(N), .DB_CYCLES(DB_CYCLES)) i_dbn (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (r_q.dbn),
        .raw_i (sync_lvl),
        .filt_o(filt_lvl)
    );

    always_comb begin
        r_d     = r_q;
        r_d.lvl = filt_lvl;
        if (bus_wen) begin
            if (hit_dout_set) r_d.dout = r_q.dout | wbits;
            if (hit_dout_clr) r_d.dout = r_q.dout & ~wbits;
            if (hit_dir_set)  r_d.dir  = r_q.dir | wbits;
            if (hit_dir_clr)  r_d.dir  = r_q.dir & ~wbits;
            if (hit_dbn_set)  r_d.dbn  = r_q.dbn | wbits;
            if (hit_dbn_clr)  r_d.dbn  = r_q.dbn & ~wbits;
        end
        r_d.rdata = '0;
        if (bus_ren) begin
            if (hit_dir_stat) r_d.rdata = 32'(r_q.dir);
            if (hit_pin_lvl)  r_d.rdata = 32'(r_q.lvl);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pad_out   = r_q.dout;
    assign pad_oe    = r_q.dir;
    assign bus_rdata = r_q.rdata;

    // R2
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wen && (hit_dout_set || hit_dout_clr)) |=> $stable(pad_out));
    // R4
    oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wen && (hit_dir_set || hit_dir_clr)) |=> $stable(pad_oe));
    // R8
    wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ren && (hit_dout_set || hit_dout_clr || hit_dir_set || hit_dir_clr
                    || hit_dbn_set || hit_dbn_clr) |=> (bus_rdata == '0));
    // R5
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ren |=> (bus_rdata == '0));
    // R3
    dout_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wen && hit_dout_clr |=> ((pad_out & $past(wbits)) == '0));

    if (N < 32) begin : g_upper
        // R9
        upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bus_ren |=> (bus_rdata[31:N] == '0));
    end
endmodule

// File: tb/test_gpio_sc_port.sv
module test_gpio_sc_port;
    localparam int L = 24;
    localparam int DB = 4;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] M = (32'h1 << L) - 1;

    logic clk = 0, rst_n = 0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wen = 0, bus_ren = 0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [L-1:0] pad_in = '0, pad_out, pad_oe;

    int checks = 0, failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_sc_port #(.NUM_LINES(L), .DB_CYCLES(DB), .ADDR_W(8)) i_gpio_sc_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_ren(bus_ren), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // behavioural reference
    logic [31:0] m_dout, m_dir, m_db, m_ext, m_rd, m_s1, m_s2, m_flt;
    int m_cnt[32];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_dout <= 0; m_dir <= 0; m_db <= 0; m_ext <= 0; m_rd <= 0;
            m_s1 <= 0; m_s2 <= 0; m_flt <= 0;
            for (int i = 0; i < 32; i++) m_cnt[i] <= 0;
        end else begin
            logic [31:0] filt;
            filt = ((m_db & m_flt) | (~m_db & m_s2)) & M;
            for (int i = 0; i < L; i++) begin
                if (!m_db[i]) begin
                    m_flt[i] <= m_s2[i]; m_cnt[i] <= 0;
                end else if (m_s2[i] == m_flt[i]) begin
                    m_cnt[i] <= 0;
                end else if (m_cnt[i] + 1 >= DB) begin
                    m_flt[i] <= m_s2[i]; m_cnt[i] <= 0;
                end else begin
                    m_cnt[i] <= m_cnt[i] + 1;
                end
            end
            m_ext <= filt;
            m_s1 <= 32'(pad_in);
            m_s2 <= m_s1;
            if (bus_wen) begin
                case (bus_addr)
                    8'h00: m_dout <= (m_dout | bus_wdata) & M;
                    8'h04: m_dout <= m_dout & ~bus_wdata;
                    8'h10: m_dir  <= (m_dir | bus_wdata) & M;
                    8'h14: m_dir  <= m_dir & ~bus_wdata;
                    8'h60: m_db   <= (m_db | bus_wdata) & M;
                    8'h64: m_db   <= m_db & ~bus_wdata;
                    default: ;
                endcase
            end
            if (bus_ren && bus_addr == 8'h18)      m_rd <= m_dir;
            else if (bus_ren && bus_addr == 8'h80) m_rd <= m_ext;
            else                                   m_rd <= 0;
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (32'(pad_out) != m_dout) begin
                failures++;
                $display("FAIL R2/R3 pad_out act=%h exp=%h", pad_out, m_dout);
            end
            checks++;
            if (32'(pad_oe) != m_dir) begin
                failures++;
                $display("FAIL R4 pad_oe act=%h exp=%h", pad_oe, m_dir);
            end
            checks++;
            if (bus_rdata != m_rd) begin
                failures++;
                $display("FAIL R5/R6/R8 rdata act=%h exp=%h", bus_rdata, m_rd);
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wen = 1;
        @(negedge clk);
        bus_wen = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_ren = 1;
        @(negedge clk);
        bus_ren = 0;
        d = bus_rdata;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        chk("R1 pad_out", 32'(pad_out), 0);
        chk("R1 pad_oe", 32'(pad_oe), 0);
        chk("R1 rdata", bus_rdata, 0);
        // R2 and R9: set all, upper bits dropped
        wr(8'h00, 32'hFFFF_FFFF);
        chk("R2 R9 set all", 32'(pad_out), M);
        // R3
        wr(8'h04, 32'h0000_F0F0);
        chk("R3 clear", 32'(pad_out), M & ~32'hF0F0);
        wr(8'h04, 32'h0);
        chk("R3 zero clear no effect", 32'(pad_out), M & ~32'hF0F0);
        wr(8'h00, 32'h0000_0010);
        chk("R2 partial set", 32'(pad_out), (M & ~32'hF0F0) | 32'h10);
        // R4
        wr(8'h10, 32'h00A5_0003);
        chk("R4 dir set", 32'(pad_oe), 32'h00A5_0003);
        wr(8'h14, 32'h0000_0001);
        chk("R4 dir clr", 32'(pad_oe), 32'h00A5_0002);
        // R5
        rd(8'h18, v);
        chk("R5 dir status", v, 32'h00A5_0002);
        @(negedge clk);
        chk("R5 idle rdata", bus_rdata, 0);
        // R8
        rd(8'h00, v);  chk("R8 set addr reads 0", v, 0);
        rd(8'h14, v);  chk("R8 clr addr reads 0", v, 0);
        rd(8'h19, v);  chk("R8 misaligned reads 0", v, 0);
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'h12, 32'hFFFF_FFFF);
        chk("R8 stray write dout", 32'(pad_out), (M & ~32'hF0F0) | 32'h10);
        chk("R8 stray write oe", 32'(pad_oe), 32'h00A5_0002);
        // R6: pad change visible three edges later
        @(negedge clk);
        pad_in = 24'h5A_3C01;
        repeat (2) @(negedge clk);
        bus_addr = 8'h80; bus_ren = 1;
        @(negedge clk);
        bus_ren = 0;
        chk("R6 too early", bus_rdata, 0);
        rd(8'h80, v);
        chk("R6 pin level", v, 32'h005A_3C01);
        // R7: debounce line 1
        wr(8'h60, 32'h0000_0002);
        pad_in[1] = 1'b1;
        repeat (2) @(negedge clk);
        pad_in[1] = 1'b0;
        repeat (10) @(negedge clk);
        rd(8'h80, v);
        chk("R7 glitch filtered", v & 32'h2, 0);
        pad_in[1] = 1'b1;
        repeat (DB + 1) @(negedge clk);
        rd(8'h80, v);
        chk("R7 not yet stable", v & 32'h2, 0);
        repeat (3) @(negedge clk);
        rd(8'h80, v);
        chk("R7 stable passes", v & 32'h2, 32'h2);
        wr(8'h64, 32'h0000_0002);
        pad_in[1] = 1'b0;
        repeat (4) @(negedge clk);
        rd(8'h80, v);
        chk("R7 disabled follows", v & 32'h2, 0);
        // R9: upper pad bits not present, reads stay in range
        rd(8'h18, v);
        chk("R9 upper read zero", v & ~M, 0);
        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule